// File: doc/BRIEF.md
# Two-Wire Channel Switch Control Slave

This block is a slave on a two-wire serial bus. It holds an 8-bit channel-enable register whose bits drive eight channel outputs; bit 7 controls the highest channel and bit 0 the lowest. A bus master addresses the block and writes bytes to change which channels are on. It can also read the register back.

SCL and SDA are sampled by the system clock. Each line passes through a two-stage synchronizer and a stability filter before any protocol logic sees it. SDA is never driven high. The `sda_oe` output tells the pad to pull the line low. Two strap inputs set the low two bits of the slave address, so four instances can share one bus.

The protocol engine is a state machine with eight states:

- `ST_IDLE`: the bus is free.
- `ST_ADDR`: eight address and direction bits are being shifted in.
- `ST_ADDR_ACK`: the address is acknowledged.
- `ST_WR_DATA` and `ST_WR_ACK`: a data byte is received, then acknowledged.
- `ST_RD_DATA` and `ST_RD_ACK`: the register byte is sent, then the master's answer bit is sampled.
- `ST_IGNORE`: the block waits for the next bus condition.

The transitions are as follows:

- A START from any state goes to `ST_ADDR`. A STOP from any state goes to `ST_IDLE`.
- From `ST_ADDR`, the falling SCL edge after the eighth bit goes to `ST_ADDR_ACK` on an address hit, and to `ST_IGNORE` on a miss.
- From `ST_ADDR_ACK`, the next falling edge goes to `ST_RD_DATA` when the direction bit is 1, and to `ST_WR_DATA` when it is 0.
- `ST_WR_DATA` goes to `ST_WR_ACK` after eight bits. `ST_WR_ACK` returns to `ST_WR_DATA` on the next falling edge.
- `ST_RD_DATA` goes to `ST_RD_ACK` after eight bits.
- From `ST_RD_ACK`, a master acknowledge returns to `ST_RD_DATA` for another copy of the byte. A no-acknowledge goes to `ST_IGNORE`.

Top module: `chsw_i2c_slave`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `chan_en` is 8'h00 and `sda_oe` is 0.
- R2: After START, the slave pulls SDA low during the ninth SCL clock of the first byte. This happens only when the byte's upper seven bits, sent MSB first, equal {1,0,0,1,0,strap_i[1],strap_i[0]}.
- R3: On an address miss the slave never drives SDA, and the data bytes that follow leave `chan_en` unchanged until the next START.
- R4: When the first byte ends in bit value 0 (write), each later 8-bit byte, sent MSB first, is copied to `chan_en` at the falling SCL edge that ends its eighth bit. Each such byte is acknowledged, and several bytes may follow one address.
- R5: When the first byte ends in bit value 1 (read), the slave sends `chan_en` MSB first. Each bit is placed on SDA while SCL is low and held while SCL is high. SDA is released for the ninth clock.
- R6: During a read, a master acknowledge (SDA low on the ninth clock) makes the slave send the register byte again. A no-acknowledge (SDA high) makes it stop driving until the next START.
- R7: A START that arrives in the middle of any byte abandons that byte and restarts address reception without a STOP.
- R8: After a STOP, `sda_oe` is 0 and the block is idle.
- R9: A pulse on SCL or SDA lasting fewer than FILT_CYC system clocks (13 by default, 52 ns at 250 MHz) has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous clear |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Low two address bits; bit 1 sits above bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| chan_en | output | 8 | Channel-enable register; 1 turns a channel on |

## Verification
The write commit and the start of the acknowledge happen in the same system-clock cycle: both are triggered by the one filtered SCL falling edge that ends the eighth data bit. The bench writes bytes back to back after one address. After each byte it requires both a low SDA in the ninth clock and the new `chan_en` value; a checker requires `chan_en` to change only while the filtered SCL is low. Repeated START is also provoked mid-byte, both after a miss and after three bits of a write data byte. The bench then confirms that the abandoned bits never reach the register and that the next address is served.

// File: rtl/chsw_pkg.sv
package chsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

endpackage

// File: rtl/chsw_line_filt.sv
module chsw_line_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          stab_cnt;

    // Synchronizer, reset to the idle-high bus level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
        end
    end

    // Take a new level only after it has held for FILT_CYC clocks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_o  <= 1'b1;
            stab_cnt <= '0;
        end else if (sync_q[SYNC_STAGES-1] == clean_o) begin
            stab_cnt <= '0;
        end else if (stab_cnt == CW'(FILT_CYC - 1)) begin
            clean_o  <= sync_q[SYNC_STAGES-1];
            stab_cnt <= '0;
        end else begin
            stab_cnt <= stab_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/chsw_bus_cond.sv
module chsw_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Bus conditions: SDA moves while SCL stays high.
    assign start_det = scl_q && scl_f && sda_q && !sda_f;
    assign stop_det  = scl_q && scl_f && !sda_q && sda_f;
    assign scl_rise  = !scl_q && scl_f;
    assign scl_fall  = scl_q && !scl_f;
endmodule

// File: rtl/chsw_bus_fsm.sv
module chsw_bus_fsm
    import chsw_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter int          STRAP_W = 2,
    parameter logic [4:0]  ADDR_HI = 5'b10010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_f,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe,
    output logic [DATA_W-1:0]  chan_en,
    output bus_state_e         state_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    bus_state_e        state_q;
    bus_state_e        state_d;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_q;
    logic              mnack_q;
    logic              byte_done;
    logic              addr_hit;
    logic              shifting;

    assign byte_done = (bit_cnt == CNT_W'(DATA_W));
    assign addr_hit  = (rx_sh[DATA_W-1:1] == {ADDR_HI, strap_i});
    assign shifting  = (state_q == ST_ADDR) || (state_q == ST_WR_DATA) ||
                       (state_q == ST_RD_DATA);

    // Next-state logic; START and STOP override every state.
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_IGNORE:   state_d = ST_IGNORE;
                ST_ADDR:     if (scl_fall && byte_done)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_d = rw_q ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                                 state_d = mnack_q ? ST_IGNORE : ST_RD_DATA;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift registers, bit counter and the channel register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            tx_sh   <= '0;
            bit_cnt <= '0;
            rw_q    <= 1'b0;
            mnack_q <= 1'b1;
            chan_en <= '0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else if (scl_rise) begin
            if (shifting) begin
                rx_sh   <= {rx_sh[DATA_W-2:0], sda_f};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (state_q == ST_RD_ACK) begin
                mnack_q <= sda_f;
            end
        end else if (scl_fall) begin
            unique case (state_q)
                ST_ADDR:     if (byte_done) rw_q <= rx_sh[0];
                ST_ADDR_ACK: begin
                                 bit_cnt <= '0;
                                 tx_sh   <= chan_en;
                             end
                ST_WR_DATA:  if (byte_done) chan_en <= rx_sh;
                ST_WR_ACK:   bit_cnt <= '0;
                ST_RD_DATA:  if (!byte_done) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                ST_RD_ACK:   begin
                                 bit_cnt <= '0;
                                 tx_sh   <= chan_en;
                             end
                default:     ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        sda_oe = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_DATA:             sda_oe = !tx_sh[DATA_W-1];
            default:                sda_oe = 1'b0;
        endcase
        state_o = state_q;
    end
endmodule

// File: rtl/chsw_i2c_slave.sv
module chsw_i2c_slave
    import chsw_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STRAP_W     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe,
    output logic [DATA_W-1:0]  chan_en
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_clean;
    logic               start_det;
    logic               stop_det;
    logic               scl_rise;
    logic               scl_fall;
    bus_state_e         fsm_state;

    // Index 1 is SCL, index 0 is SDA.
    assign line_raw = {scl_i, sda_i};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        chsw_line_filt #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYC    (FILT_CYC)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (line_raw[gi]),
            .clean_o (line_clean[gi])
        );
    end

    chsw_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (line_clean[1]),
        .sda_f     (line_clean[0]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    chsw_bus_fsm #(
        .DATA_W  (DATA_W),
        .STRAP_W (STRAP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_f     (line_clean[0]),
        .strap_i   (strap_i),
        .sda_oe    (sda_oe),
        .chan_en   (chan_en),
        .state_o   (fsm_state)
    );
endmodule

// File: rtl/chsw_i2c_slave_chk.sv
module chsw_i2c_slave_chk
    import chsw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_f,
    input logic              stop_det,
    input logic              sda_oe,
    input logic [DATA_W-1:0] chan_en,
    input bus_state_e        state
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_clear_chk: assert (chan_en == '0 && !sda_oe);
        end
    end

    // R4
    chan_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> !scl_f);

    // R5
    sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R3
    ignore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> $stable(chan_en));
endmodule

bind chsw_i2c_slave chsw_i2c_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (line_clean[1]),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .chan_en  (chan_en),
    .state    (fsm_state)
);

// File: tb/chsw_i2c_slave_test.sv
module chsw_i2c_slave_test;
    localparam int Q = 25;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [6:0] MY_ADDR = {5'b10010, STRAP};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [7:0] chan_en;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    chsw_i2c_slave uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_bus),
        .strap_i (STRAP),
        .sda_oe  (sda_oe),
        .chan_en (chan_en)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b1; wt(Q);
    endtask

    // g: 0 clean, 1 short SDA pulse while SCL high, 2 short SCL pulse while SCL low
    task automatic put_bit(input logic b, input int g);
        m_sda = b;
        if (g == 2) begin
            wt(8); m_scl = 1'b1; wt(6); m_scl = 1'b0; wt(Q - 14);
        end else begin
            wt(Q);
        end
        m_scl = 1'b1;
        if (g == 1) begin
            wt(8); m_sda = ~b; wt(6); m_sda = b; wt(2 * Q - 14);
        end else begin
            wt(2 * Q);
        end
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        b = sda_bus; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, input int gbit, input int gkind,
                             output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(d[i], (i == gbit) ? gkind : 0);
        get_bit(x);
        acked = !x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(nack, 0);
    endtask

    task automatic t_reset();
        check(chan_en == 8'h00, "R1 reset chan", chan_en, 0);
        check(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
    endtask

    task automatic t_write_single();
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, -1, 0, a);
        check(a, "R2 address ack", a, 1);
        send_byte(8'hA5, -1, 0, a);
        check(a, "R4 data ack", a, 1);
        check(chan_en == 8'hA5, "R4 single write", chan_en, 8'hA5);
        bus_stop();
        wt(Q);
        check(sda_oe == 1'b0, "R8 idle after stop", sda_oe, 0);
    endtask

    task automatic t_write_multi();
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, -1, 0, a);
        send_byte(8'h3C, -1, 0, a);
        check(a && chan_en == 8'h3C, "R4 first of burst", chan_en, 8'h3C);
        send_byte(8'hC3, -1, 0, a);
        check(a && chan_en == 8'hC3, "R4 second of burst", chan_en, 8'hC3);
        bus_stop();
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, -1, 0, a);
        check(a, "R2 read address ack", a, 1);
        recv_byte(d, 1'b0);
        check(d == 8'hC3, "R5 read byte", d, 8'hC3);
        recv_byte(d, 1'b1);
        check(d == 8'hC3, "R6 repeated read", d, 8'hC3);
        wt(Q);
        check(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte({5'b10010, 2'b01, 1'b0}, -1, 0, a);
        check(!a, "R3 strap miss no ack", a, 0);
        send_byte(8'hFF, -1, 0, a);
        check(!a && chan_en == 8'hC3, "R3 data ignored", chan_en, 8'hC3);
        bus_stop();
        bus_start();
        send_byte({5'b00010, STRAP, 1'b0}, -1, 0, a);
        check(!a, "R3 prefix miss no ack", a, 0);
        bus_stop();
    endtask

    task automatic t_rstart();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({5'b11111, STRAP, 1'b0}, -1, 0, a);
        send_byte(8'h00, -1, 0, a);
        bus_start();
        send_byte({MY_ADDR, 1'b0}, -1, 0, a);
        check(a, "R7 ack after repeated start", a, 1);
        send_byte(8'h5A, -1, 0, a);
        check(chan_en == 8'h5A, "R7 write after repeated start", chan_en, 8'h5A);
        put_bit(1'b1, 0); put_bit(1'b0, 0); put_bit(1'b1, 0);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, -1, 0, a);
        recv_byte(d, 1'b1);
        check(a && d == 8'h5A, "R7 partial byte dropped", d, 8'h5A);
        bus_stop();
    endtask

    task automatic t_glitch();
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, 3, 1, a);
        check(a, "R9 address through sda pulse", a, 1);
        send_byte(8'h96, 5, 2, a);
        check(a && chan_en == 8'h96, "R9 data through scl pulse", chan_en, 8'h96);
        send_byte(8'h69, 2, 1, a);
        check(a && chan_en == 8'h69, "R9 data through sda pulse", chan_en, 8'h69);
        bus_stop();
    endtask

    task automatic t_clear();
        rst_n = 1'b0; wt(3);
        check(chan_en == 8'h00 && !sda_oe, "R1 clear input", chan_en, 0);
        rst_n = 1'b1; wt(4);
        check(chan_en == 8'h00, "R1 after clear", chan_en, 0);
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_write_single();
        t_write_multi();
        t_read();
        t_mismatch();
        t_rstart();
        t_glitch();
        t_clear();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wt(150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule